// File: doc/BRIEF.md
# Autoreload Timer with Input Capture

This block is an 8-bit up-counter that never wraps to zero. When it steps past its all-ones value it restarts from a value held in a software-written reload register, so the reload value sets the period. A separate prescaled enable input decides on which clock cycles the counter advances.

Next to the counter sits an input-capture unit. It brings an external pin into the clock domain through a two-stage synchronizer and watches for a rising edge. On each rising edge it copies the counter into a capture register and raises a capture flag. The flag cannot be changed by writes. It clears only as a side effect of reading the capture register, and it has no defined value after reset, so software reads the capture register once before it uses the flag.

A byte-wide register port reaches four locations, selected by `addr`:
- 0: reload register, read and write.
- 1: counter, read only.
- 2: control/status register.
- 3: capture register, read only.

The control/status register holds the capture interrupt enable, the capture flag, a timebase period select bit, and a timebase interrupt enable and flag. A timebase tick input sets the timebase flag. One interrupt output combines both sources.

Top module: `arl_cap_timer`

## Requirements
- R1: After reset, the reload register, the counter and the capture register read 00h. Every bit of the control/status register (address 2) except bit 6 reads 0.
- R2: On each clock edge where `cnt_en` is 1 and the counter is below FFh, the counter rises by 1. While `cnt_en` is 0 the counter holds its value.
- R3: On a clock edge where `cnt_en` is 1 and the counter is FFh, the counter takes the reload value held before that edge, not 00h.
- R4: A write to address 0 stores `wdata` in the reload register, and address 0 reads it back. Writes to address 1 (counter) and address 3 (capture) have no effect.
- R5: A rising edge on `cap_in` is acted on at the third clock edge after it. At that edge the capture register (address 3) takes the counter value and the capture flag (control/status bit 6) becomes 1. A falling edge causes no capture.
- R6: Writing 0 or 1 to control/status bit 6 leaves the capture flag unchanged.
- R7: A read of address 3 clears the capture flag at the end of the read cycle. If a capture falls on that same edge, the flag stays 1.
- R8: Control/status bits 7 (capture interrupt enable), 5 (timebase period select) and 4 (timebase interrupt enable) are read/write. Bits 2:0 always read 0.
- R9: A `tb_tick` pulse sets control/status bit 3 (timebase flag). Writing 0 to bit 3 clears it. Writing 1 to bit 3 has no effect. A tick on the same edge as a clearing write wins.
- R10: `irq` is 1 exactly when (bit 6 and bit 7) or (bit 3 and bit 4) are both set.
- R11: `tb_period_sel` always equals control/status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Prescaled count enable |
| tb_tick | input | 1 | Timebase event pulse |
| cap_in | input | 1 | Asynchronous capture pin |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 reload, 1 counter, 2 control/status, 3 capture |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; combinational from `addr` |
| tb_period_sel | output | 1 | Timebase period select bit |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples a read in the same cycle as the strobe. Writes, counter steps and read side effects all appear after the next clock edge.

A capture shows up three edges after the pin rises. The bench checks the flag between the second and third edges, where it must still be 0, and again after the third edge, where it must be 1.

To make a read and a capture land on the same edge, the bench times the capture-register read so that its closing edge is that third edge. All stimulus is applied one nanosecond after a rising edge. A scoreboard queue pairs each expected value with the falling edge of the cycle in which it is due.

// File: rtl/arl_cap_pkg.sv
// Package: shared register addresses and control/status bit positions
// for the autoreload capture timer. Assumes an 8-bit data path.
package arl_cap_pkg;
    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_COUNT  = 2'd1,
        REG_CTRL   = 2'd2,
        REG_CAPT   = 2'd3
    } arl_reg_e;

    localparam int CTL_CAP_IE  = 7;
    localparam int CTL_CAP_FLG = 6;
    localparam int CTL_TB_SEL  = 5;
    localparam int CTL_TB_IE   = 4;
    localparam int CTL_TB_FLG  = 3;
endpackage

// File: rtl/arl_counter.sv
// Module: autoreload up-counter. Advances on cnt_en. On stepping past the
// all-ones value it loads the reload value instead of wrapping to zero.
// Assumes: reload is stable register state from the register block.
module arl_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic at_top;
    assign at_top = (cnt == TOP);

    // Counter state: reset, reload on overflow, otherwise increment when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt_en)
            cnt <= at_top ? reload : cnt + 1'b1;
    end

    // R2: increment below the top value
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
    // R2: hold when not enabled
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt));
    // R3: overflow loads the reload value
    a_r3_reload_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt == TOP) |=> cnt == $past(reload));
endmodule

// File: rtl/arl_capture.sv
// Module: input capture. Synchronizes cap_in through SYNC_STAGES flops and
// detects a rising edge. On that edge it latches cnt and sets the flag.
// The flag has no reset and clears on a capture-register read; a capture
// on the same edge wins.
// Assumes: rd_cap is a single-cycle read strobe for the capture register.
module arl_capture #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic [W-1:0] cnt,
    input  logic         rd_cap,
    output logic [W-1:0] cap_val,
    output logic         cap_flag
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   evt;

    // Synchronizer chain: first stage samples the pin, later stages shift.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= cap_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Edge history: last synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign evt = sync_q[SYNC_STAGES-1] & ~prev_q;

    // Capture register: latch counter on a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_val <= '0;
        else if (evt) cap_val <= cnt;
    end

    // Capture flag: no reset; set by a capture, cleared by a read; set wins.
    always_ff @(posedge clk) begin
        if (evt)         cap_flag <= 1'b1;
        else if (rd_cap) cap_flag <= 1'b0;
    end

    // R5: capture latches the counter and raises the flag
    a_r5_capture_latch: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (cap_val == $past(cnt)) && cap_flag);
    // R7: a read without a capture clears the flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && !evt) |=> !cap_flag);
    // R6: without a capture or a read, the flag holds
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cap && !evt) |=> cap_flag == $past(cap_flag));
    // R5: the capture value changes only on a capture
    a_r5_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cap_val));
endmodule

// File: rtl/arl_regs.sv
// Module: register block. Holds the reload value and the control bits,
// decodes writes, muxes read data, and makes the capture-read strobe.
// Assumes: one access per cycle; reads are side-effect free except address 3.
module arl_regs
    import arl_cap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic         tb_tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cap_val,
    input  logic         cap_flag,
    output logic [W-1:0] rdata,
    output logic [W-1:0] reload,
    output logic         rd_cap,
    output logic         tb_period_sel,
    output logic         irq
);
    logic         cap_ie;
    logic         tb_ie;
    logic         tb_flag;
    logic         wr_reload;
    logic         wr_ctrl;
    logic [W-1:0] ctrl_view;

    assign wr_reload = wr_en && (addr == REG_RELOAD);
    assign wr_ctrl   = wr_en && (addr == REG_CTRL);
    assign rd_cap    = rd_en && (addr == REG_CAPT);

    // Reload register: software write only.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload <= '0;
        else if (wr_reload) reload <= wdata;
    end

    // Control enables and period select: plain read/write bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ie        <= 1'b0;
            tb_period_sel <= 1'b0;
            tb_ie         <= 1'b0;
        end else if (wr_ctrl) begin
            cap_ie        <= wdata[CTL_CAP_IE];
            tb_period_sel <= wdata[CTL_TB_SEL];
            tb_ie         <= wdata[CTL_TB_IE];
        end
    end

    // Timebase flag: set by tick, cleared by writing 0; tick wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                            tb_flag <= 1'b0;
        else if (tb_tick)                      tb_flag <= 1'b1;
        else if (wr_ctrl && !wdata[CTL_TB_FLG]) tb_flag <= 1'b0;
    end

    // Control/status view: unused low bits read as zero.
    always_comb begin
        ctrl_view              = '0;
        ctrl_view[CTL_CAP_IE]  = cap_ie;
        ctrl_view[CTL_CAP_FLG] = cap_flag;
        ctrl_view[CTL_TB_SEL]  = tb_period_sel;
        ctrl_view[CTL_TB_IE]   = tb_ie;
        ctrl_view[CTL_TB_FLG]  = tb_flag;
    end

    // Read mux by address.
    always_comb begin
        unique case (addr)
            REG_RELOAD: rdata = reload;
            REG_COUNT:  rdata = cnt;
            REG_CTRL:   rdata = ctrl_view;
            default:    rdata = cap_val;
        endcase
    end

    assign irq = (cap_flag & cap_ie) | (tb_flag & tb_ie);

    // R4: reload write lands on the next edge
    a_r4_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> reload == $past(wdata));
    // R4: reload unchanged without a write to it
    a_r4_reload_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reload |=> $stable(reload));
    // R9: a tick always leaves the flag set
    a_r9_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tb_tick |=> tb_flag);
    // R9: writing 1 to the flag bit cannot raise it
    a_r9_write_one_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_tick && !tb_flag) |=> !tb_flag);
endmodule

// File: rtl/arl_cap_timer.sv
// Module: top of the autoreload timer with input capture. Connects the
// counter, the capture unit and the register block.
// Assumes: W is at least 8 so the control/status bit positions fit.
module arl_cap_timer #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         tb_tick,
    input  logic         cap_in,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         tb_period_sel,
    output logic         irq
);
    logic [W-1:0] cnt;
    logic [W-1:0] reload;
    logic [W-1:0] cap_val;
    logic         cap_flag;
    logic         rd_cap;

    arl_counter #(.W(W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .reload (reload),
        .cnt    (cnt)
    );

    arl_capture #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_in   (cap_in),
        .cnt      (cnt),
        .rd_cap   (rd_cap),
        .cap_val  (cap_val),
        .cap_flag (cap_flag)
    );

    arl_regs #(.W(W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .tb_tick       (tb_tick),
        .cnt           (cnt),
        .cap_val       (cap_val),
        .cap_flag      (cap_flag),
        .rdata         (rdata),
        .reload        (reload),
        .rd_cap        (rd_cap),
        .tb_period_sel (tb_period_sel),
        .irq           (irq)
    );
endmodule

// File: tb/arl_cap_timer_tb.sv
`timescale 1ns/1ps
module arl_cap_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       tb_tick = 1'b0;
    logic       cap_in = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tb_period_sel;
    logic       irq;

    always #2 clk = ~clk;

    arl_cap_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tb_tick(tb_tick),
        .cap_in(cap_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tb_period_sel(tb_period_sel), .irq(irq)
    );

    // Scoreboard item: what to sample (0 rdata, 1 irq, 2 tb_period_sel).
    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t queue_q[$];
    logic  mon_req = 1'b0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    // Monitor: pops and compares one item per requested cycle, away from the edge.
    always @(negedge clk) begin
        if (mon_req && queue_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = queue_q.pop_front();
            case (it.sel)
                0:       act = rdata;
                1:       act = {7'd0, irq};
                default: act = {7'd0, tb_period_sel};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = a; mon_req = 1'b1;
        queue_q.push_back('{0, e, tag});
        @(posedge clk); #1;
        rd_en = 1'b0; mon_req = 1'b0;
    endtask

    task automatic probe(input int s, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        mon_req = 1'b1;
        queue_q.push_back('{s, e, tag});
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic run_cnt(input int k);
        @(posedge clk); #1;
        cnt_en = 1'b1;
        repeat (k) @(posedge clk);
        #1 cnt_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state (capture read first to define the flag)
        do_read(2'd3, 8'h00, "R1 capture reset");
        do_read(2'd2, 8'h00, "R1 ctrl reset");
        do_read(2'd0, 8'h00, "R1 reload reset");
        do_read(2'd1, 8'h00, "R1 counter reset");
        probe(1, 8'h00, "R1 irq reset");

        // R4 reload read/write, counter write ignored
        do_write(2'd0, 8'hF0);
        do_read(2'd0, 8'hF0, "R4 reload readback");
        do_write(2'd1, 8'h55);
        do_read(2'd1, 8'h00, "R4 counter write ignored");
        do_write(2'd3, 8'hAA);
        do_read(2'd3, 8'h00, "R4 capture write ignored");

        // R2 counting and holding
        run_cnt(5);
        do_read(2'd1, 8'h05, "R2 count five");
        do_read(2'd1, 8'h05, "R2 hold when disabled");
        run_cnt(250);
        do_read(2'd1, 8'hFF, "R2 count to top");

        // R3 overflow reloads
        run_cnt(1);
        do_read(2'd1, 8'hF0, "R3 reload on overflow");
        run_cnt(3);
        do_read(2'd1, 8'hF3, "R3 count after reload");

        // R5 capture timing and value
        #0 cap_in = 1'b1;
        @(posedge clk);
        do_read(2'd2, 8'h00, "R5 flag not yet set");
        do_read(2'd2, 8'h40, "R5 flag set third edge");
        do_read(2'd3, 8'hF3, "R5 capture value");
        do_read(2'd2, 8'h00, "R7 read clears flag");

        // R6/R8 flag write ignored, enable bit read/write
        do_write(2'd2, 8'hC0);
        do_read(2'd2, 8'h80, "R6 write one ignored");
        probe(1, 8'h00, "R10 irq low without flag");
        cap_in = 1'b0;
        repeat (5) @(posedge clk);
        do_read(2'd2, 8'h80, "R5 falling edge no capture");
        #0 cap_in = 1'b1;
        repeat (4) @(posedge clk);
        probe(1, 8'h01, "R10 irq capture source");
        do_write(2'd2, 8'h80);
        do_read(2'd2, 8'hC0, "R6 write zero ignored");
        do_write(2'd2, 8'h00);
        probe(1, 8'h00, "R10 irq masked");
        do_read(2'd2, 8'h40, "R8 enable cleared");

        // R7 read and capture on the same edge: set wins
        cap_in = 1'b0;
        repeat (5) @(posedge clk);
        #1 cap_in = 1'b1;
        @(posedge clk);
        do_read(2'd3, 8'hF3, "R7 capture read same edge");
        do_read(2'd2, 8'h40, "R7 set wins");
        do_read(2'd3, 8'hF3, "R7 second read");
        do_read(2'd2, 8'h00, "R7 cleared after read");

        // R9/R10/R11 timebase
        do_write(2'd2, 8'h38);
        do_read(2'd2, 8'h30, "R9 write one no effect");
        probe(2, 8'h01, "R11 period select high");
        probe(1, 8'h00, "R10 irq low no tb flag");
        @(posedge clk); #1 tb_tick = 1'b1;
        @(posedge clk); #1 tb_tick = 1'b0;
        do_read(2'd2, 8'h38, "R9 tick sets flag");
        probe(1, 8'h01, "R10 irq timebase source");
        do_write(2'd2, 8'h30);
        do_read(2'd2, 8'h30, "R9 write zero clears");
        probe(1, 8'h00, "R10 irq after clear");
        do_write(2'd2, 8'h07);
        do_read(2'd2, 8'h00, "R8 low bits read zero");
        probe(2, 8'h00, "R11 period select low");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule